// File: doc/BRIEF.md
# Serial EEPROM Paged Write Sequencer

This block sits on the host side of a byte-addressed serial EEPROM. A single start pulse supplies a start address and a byte count. The block then pulls that many bytes from a valid/ready input stream and writes them to the memory over an SPI mode 0 master port. The memory accepts at most one 64-byte page per programming cycle, so the block cuts the transfer at page boundaries. The first burst runs only to the end of the page that holds the start address. Each later burst covers one whole page, or whatever is left if that is less.

Each burst uses its own chip-select frames in a fixed order. First comes a one-byte enable frame. Next comes a program frame that carries the opcode, the address high byte, the address low byte and the data bytes, and chip select rises straight after the last data byte. Last come one or more status frames, repeated while the memory reports that it is busy. No disable command is sent, because the memory clears its enable latch itself when the programming cycle ends.

Back-pressure on the input stream works as follows. `in_ready` depends only on the sequencer's state and never on `in_valid`. A byte moves only on a cycle where both signals are high. When `in_valid` stays low during the data phase, chip select stays low and SCK stays idle until the next byte arrives.

Top module: `eeprom_page_writer`

## Requirements
- R1: Burst lengths follow the page size. The first burst is 64 minus the low six address bits, capped by the count. Each later burst is the smaller of 64 and the bytes remaining. Each burst's address is the previous burst's address plus the previous burst length.
- R2: Before every program frame there is a frame that holds exactly one byte, 0x06.
- R3: A program frame is 0x02, then address bits 15:8, then address bits 7:0, then exactly the burst's data bytes in stream order. Chip select rises straight after the last data byte.
- R4: After each program frame, the block sends status frames of two bytes each (0x05, then a 0x00 filler), each in its own frame. It repeats them while bit 0 of the second byte received on `miso` is 1. The next enable frame, or the end of the job, follows only once a status frame returns bit 0 clear.
- R5: The SPI port works in mode 0. SCK idles low and is low whenever `cs_n` changes. Data goes out MSB first. `mosi` holds still while SCK is high. Every SCK high phase lasts CLK_DIV clock cycles.
- R6: Between frames, `cs_n` stays high for at least CS_GAP_SCK × 2 × CLK_DIV clock cycles.
- R7: `in_ready` is high only during the data phase of a program frame, with `cs_n` low, and one byte is taken per handshake.
- R8: `done_o` is a one-cycle pulse, given once per job after the final status frame reports bit 0 clear. `busy_o` is high from the cycle after an accepted start until that pulse.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The running job's frames do not change, and it gives only one done pulse.
- R10: A start with a count of zero gives `done_o` on the next cycle and sends no frames.
- R11: After reset, `cs_n` is high, SCK is low, and `in_ready`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a job when the block is idle |
| addr_i | input | 16 | Start address in the memory |
| count_i | input | CNT_W | Number of bytes to write |
| in_valid | input | 1 | A data byte is offered |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | The block takes the byte this cycle if `in_valid` is high |
| sck | output | 1 | SPI clock, mode 0 |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle pulse when a job ends |

## Verification
The bench aims at start addresses that sit partway into a page and at counts that end partway into a page. A block that ran fixed 64-byte bursts would wrap inside the memory page and overwrite its first bytes. The bench's model of the memory reports busy for a set number of polls. A block that stopped polling too early would start the next enable frame while the memory was still programming. Any stray byte after the data, or a command sent without a new chip-select frame, shows up as a frame that is too long or an extra frame in the compared frame list. Further stimulus covers a stalled input stream, a start pulse during a job and a zero count. These catch a block that lets SCK run without data, that restarts mid-job, or that hangs when it has nothing to write.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] FILLER  = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WEN, ST_OPC, ST_AHI, ST_ALO, ST_DATA, ST_RDSR, ST_STAT, ST_GAP
  } st_e;
endpackage

// File: rtl/eepw_spi_shift.sv
module eepw_spi_shift #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  assign mosi = sh_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      rx    <= '0;
      sck   <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy  <= 1'b1;
          sh_q  <= tx;
          bit_q <= '0;
          cnt_q <= '0;
          sck   <= 1'b0;
        end
      end else if (cnt_q == DW'(CLK_DIV - 1)) begin
        cnt_q <= '0;
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_q == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_q <= cnt_q + DW'(1);
      end
    end
  end
endmodule

// File: rtl/eepw_burst_calc.sv
module eepw_burst_calc #(
  parameter int PAGE_BYTES = 64,
  parameter int CNT_W      = 16,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int LW = PW + 1
) (
  input  logic [PW-1:0]    offset,
  input  logic [CNT_W-1:0] remain,
  output logic [LW-1:0]    burst
);
  localparam int WW = (CNT_W > LW) ? CNT_W : LW;

  logic [WW-1:0] room_w;
  logic [WW-1:0] rem_w;

  always_comb begin
    room_w = WW'(PAGE_BYTES) - WW'(offset);
    rem_w  = WW'(remain);
    burst  = (rem_w < room_w) ? LW'(rem_w) : LW'(room_w);
  end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int PAGE_BYTES = 64,
  parameter int CNT_W      = 16,
  parameter int CS_GAP_SCK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [15:0]      addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             busy_o,
  output logic             done_o
);
  localparam int PW      = $clog2(PAGE_BYTES);
  localparam int LW      = PW + 1;
  localparam int GAP_CYC = CS_GAP_SCK * 2 * CLK_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);

  st_e              state_q, gap_ret_q;
  logic             issued_q;
  logic [15:0]      addr_q;
  logic [CNT_W-1:0] remain_q;
  logic [LW-1:0]    left_q;
  logic [GW-1:0]    gap_q;
  logic             stat_bit_q;
  logic             done_q;

  logic             sh_go, sh_busy, sh_done;
  logic [7:0]       sh_tx, sh_rx;
  logic             cmd_state;
  logic [PW-1:0]    bc_off;
  logic [CNT_W-1:0] bc_rem;
  logic [LW-1:0]    burst;

  assign bc_off = (state_q == ST_IDLE) ? addr_i[PW-1:0] : addr_q[PW-1:0];
  assign bc_rem = (state_q == ST_IDLE) ? count_i : remain_q;

  eepw_burst_calc #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_burst (
    .offset(bc_off), .remain(bc_rem), .burst(burst)
  );

  always_comb begin
    cmd_state = 1'b0;
    sh_tx     = FILLER;
    unique case (state_q)
      ST_WEN:  begin cmd_state = 1'b1; sh_tx = OP_WEN;       end
      ST_OPC:  begin cmd_state = 1'b1; sh_tx = OP_PROG;      end
      ST_AHI:  begin cmd_state = 1'b1; sh_tx = addr_q[15:8]; end
      ST_ALO:  begin cmd_state = 1'b1; sh_tx = addr_q[7:0];  end
      ST_DATA: sh_tx = in_data;
      ST_RDSR: begin cmd_state = 1'b1; sh_tx = OP_STAT;      end
      ST_STAT: begin cmd_state = 1'b1; sh_tx = FILLER;       end
      default: sh_tx = FILLER;
    endcase
  end

  assign in_ready = (state_q == ST_DATA) && !issued_q;
  assign sh_go    = (cmd_state && !issued_q) || (in_valid && in_ready);
  assign cs_n     = (state_q == ST_IDLE) || (state_q == ST_GAP);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

  eepw_spi_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx(sh_tx), .miso(miso),
    .sck(sck), .mosi(mosi), .busy(sh_busy), .done(sh_done), .rx(sh_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      gap_ret_q  <= ST_IDLE;
      issued_q   <= 1'b0;
      addr_q     <= '0;
      remain_q   <= '0;
      left_q     <= '0;
      gap_q      <= '0;
      stat_bit_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sh_go && !sh_busy) issued_q <= 1'b1;
      if (sh_done) issued_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (count_i == '0) begin
            done_q <= 1'b1;
          end else begin
            addr_q   <= addr_i;
            remain_q <= count_i;
            left_q   <= burst;
            state_q  <= ST_WEN;
          end
        end
        ST_WEN: if (sh_done) begin
          gap_ret_q <= ST_OPC;
          state_q   <= ST_GAP;
        end
        ST_OPC:  if (sh_done) state_q <= ST_AHI;
        ST_AHI:  if (sh_done) state_q <= ST_ALO;
        ST_ALO:  if (sh_done) state_q <= ST_DATA;
        ST_DATA: if (sh_done) begin
          addr_q   <= addr_q + 16'd1;
          remain_q <= remain_q - CNT_W'(1);
          left_q   <= left_q - LW'(1);
          if (left_q == LW'(1)) begin
            gap_ret_q <= ST_RDSR;
            state_q   <= ST_GAP;
          end
        end
        ST_RDSR: if (sh_done) state_q <= ST_STAT;
        ST_STAT: if (sh_done) begin
          stat_bit_q <= sh_rx[0];
          gap_ret_q  <= ST_IDLE;
          state_q    <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_q == GW'(GAP_CYC - 1)) begin
            gap_q <= '0;
            if (gap_ret_q != ST_IDLE) begin
              state_q <= gap_ret_q;
            end else if (stat_bit_q) begin
              state_q <= ST_RDSR;
            end else if (remain_q == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              left_q  <= burst;
              state_q <= ST_WEN;
            end
          end else begin
            gap_q <= gap_q + GW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eepw_chk.sv
module eepw_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic in_ready,
  input logic sck,
  input logic cs_n,
  input logic mosi,
  input logic busy_o,
  input logic done_o
);
  // R5
  cs_edge_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> !sck);

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R7
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cs_n);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> (busy_o || done_o));

  // R5
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
endmodule

bind eeprom_page_writer eepw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_ready(in_ready),
  .sck(sck), .cs_n(cs_n), .mosi(mosi), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
  localparam int DIV = 2;
  localparam int GAP = 2 * 2 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [15:0] count_i = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, sck, cs_n, mosi, busy_o, done_o;
  logic miso_r = 1'b0;

  always #5 clk = ~clk;

  eeprom_page_writer #(.CLK_DIV(DIV), .PAGE_BYTES(64), .CNT_W(16), .CS_GAP_SCK(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .count_i(count_i),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso_r),
    .busy_o(busy_o), .done_o(done_o)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit wd_hit = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory model: captures frames, answers status reads
  byte unsigned cur[$];
  byte unsigned got_b[$];
  int got_l[$];
  logic [7:0] sr = '0;
  int bc = 0;
  int busy_left = 0;
  int poll_cfg = 0;
  logic [7:0] stat_now = '0;

  always @(negedge cs_n) begin
    bc = 0;
    cur.delete();
    miso_r = 1'b0;
  end

  always @(posedge sck) if (!cs_n) begin
    sr = {sr[6:0], mosi};
    bc++;
    if (bc % 8 == 0) cur.push_back(sr);
    if (bc == 8) stat_now = (busy_left > 0) ? 8'h03 : 8'h02;
    if (bc >= 8 && bc < 16 && cur[0] == 8'h05) miso_r = stat_now[15 - bc];
    else miso_r = 1'b0;
  end

  always @(posedge cs_n) if (cur.size() > 0) begin
    got_l.push_back(cur.size());
    foreach (cur[i]) got_b.push_back(cur[i]);
    if (bc % 8 != 0) chk(1'b0, "R5", "partial byte in frame", bc, 8);
    if (cur[0] == 8'h02) busy_left = poll_cfg;
    else if (cur[0] == 8'h05 && busy_left > 0) busy_left--;
    cur.delete();
  end

  // per-clock protocol monitor
  logic p_sck = 1'b0, p_mosi = 1'b0, p_cs = 1'b1;
  int hi_cnt = 0;
  int cs_hi = 1000;
  int done_cnt = 0;
  bit stall = 1'b0;
  byte unsigned src[$];
  bit hs_pend = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      chk(1'b0, "R8", "watchdog expired", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (rst_n) begin
      if (done_o) done_cnt++;
      if (in_ready && cs_n) chk(1'b0, "R7", "ready outside frame", 1, 0);
      if (cs_n && sck) chk(1'b0, "R5", "sck high while deselected", 1, 0);
      if (sck && p_sck && mosi != p_mosi) chk(1'b0, "R5", "mosi moved in high phase", mosi, p_mosi);
      if (sck) hi_cnt++;
      if (!sck && p_sck) begin
        chk(hi_cnt == DIV, "R5", "sck high width", hi_cnt, DIV);
        hi_cnt = 0;
      end
      if (cs_n) cs_hi++;
      if (!cs_n && p_cs) begin
        chk(cs_hi >= GAP, "R6", "deselect gap", cs_hi, GAP);
        cs_hi = 0;
      end
      // stream feeder
      if (hs_pend) void'(src.pop_front());
      in_valid = (src.size() > 0) && !(stall && (cyc % 5 < 2));
      in_data = (src.size() > 0) ? src[0] : 8'h00;
      hs_pend = in_valid && in_ready;
    end
    p_sck = sck; p_mosi = mosi; p_cs = cs_n;
  end

  byte unsigned exp_b[$];
  int exp_l[$];

  task automatic build(int a, int n, int seed);
    int r = n;
    int k = 0;
    exp_b.delete(); exp_l.delete(); src.delete();
    while (r > 0) begin
      int b = 64 - (a % 64);
      if (r < b) b = r;
      exp_l.push_back(1); exp_b.push_back(8'h06);
      exp_l.push_back(3 + b);
      exp_b.push_back(8'((a >> 8) & 8'hff) == 0 ? 8'h02 : 8'h02);
      exp_b.push_back(8'((a >> 8) & 255));
      exp_b.push_back(8'(a & 255));
      for (int i = 0; i < b; i++) begin
        byte unsigned d = 8'((seed + k * 13) & 255);
        exp_b.push_back(d); src.push_back(d); k++;
      end
      for (int p = 0; p <= poll_cfg; p++) begin
        exp_l.push_back(2); exp_b.push_back(8'h05); exp_b.push_back(8'h00);
      end
      a += b; r -= b;
    end
  endtask

  task automatic run_job(string req, int a, int n, int polls, bit stl, bit poke);
    int w = 0;
    poll_cfg = polls; stall = stl;
    build(a, n, a + n);
    got_b.delete(); got_l.delete();
    done_cnt = 0;
    @(negedge clk);
    addr_i = 16'(a); count_i = 16'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
    if (poke) begin
      repeat (200) @(negedge clk);
      addr_i = 16'h1234; count_i = 16'd5; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt == 0 && w < 60000) begin @(negedge clk); w++; end
    chk(done_cnt == 1, req, "done seen", done_cnt, 1);
    repeat (30) @(negedge clk);
    chk(done_cnt == 1, "R8", "single done pulse", done_cnt, 1);
    chk(busy_o == 1'b0, "R8", "idle after done", busy_o, 0);
    chk(got_l.size() == exp_l.size(), req, "frame count", got_l.size(), exp_l.size());
    for (int i = 0; i < exp_l.size() && i < got_l.size(); i++)
      chk(got_l[i] == exp_l[i], req, $sformatf("frame %0d length", i), got_l[i], exp_l[i]);
    chk(got_b.size() == exp_b.size(), "R3", "byte count", got_b.size(), exp_b.size());
    for (int i = 0; i < exp_b.size() && i < got_b.size(); i++)
      if (got_b[i] != exp_b[i])
        chk(1'b0, req, $sformatf("byte %0d", i), got_b[i], exp_b[i]);
    checks++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n == 1'b1, "R11", "cs_n in reset", cs_n, 1);
    chk(sck == 1'b0, "R11", "sck in reset", sck, 0);
    chk(in_ready == 1'b0, "R11", "ready in reset", in_ready, 0);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R11", "busy/done in reset", busy_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2 R3 single short burst at page start
    run_job("R2", 16'h0000, 8, 1, 1'b0, 1'b0);
    // R1 R4 unaligned start, three bursts 11/64/25, busy polls, stalled stream (R7)
    run_job("R1", 16'h0035, 100, 2, 1'b1, 1'b0);
    // R3 one full page at the top of the array, no busy polls
    run_job("R3", 16'h3FC0, 64, 0, 1'b0, 1'b0);
    // R9 bursts of 1 and 1 across a boundary, start pulse during the job
    run_job("R9", 16'h007F, 2, 3, 1'b1, 1'b1);
    // R4 many polls on a mid-page burst
    run_job("R4", 16'h0102, 30, 5, 1'b0, 1'b0);
    // R10 zero count
    got_l.delete(); done_cnt = 0;
    @(negedge clk);
    addr_i = 16'h0040; count_i = 16'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b1, "R10", "done next cycle", done_o, 1);
    repeat (50) @(negedge clk);
    chk(got_l.size() == 0, "R10", "no frames", got_l.size(), 0);
    chk(done_cnt == 1, "R10", "one done", done_cnt, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule